// File: doc/BRIEF.md
# Framed Burst Word Transmitter

This block feeds a parallel-port receiver from the read side of a word FIFO. It watches the FIFO fill level and holds off until more than a threshold of words is buffered. Once that happens it sends one burst, framed by two strobes. The frame strobe covers the whole burst. The line strobe marks each group of consecutive samples, and a one-cycle idle slot separates one group from the next.

The two strobes and the FIFO read strobe are launched on the rising edge of the port clock. The data word is launched on the falling edge, so it sits centred under the next rising edge for a receiver that samples on rising edges. The FIFO must be show-ahead: its read data always presents the head word, and a read strobe that is high at a rising edge advances the head. With the default parameters a burst is 16 lines of 16 samples each, which takes 272 clock cycles and consumes 256 words. After a burst the block returns to waiting.

Top module: `frame_line_tx`

## Requirements
- R1: A synchronous reset forces the wait state. After reset, txFrame, txLine and fifoRd are 0 and txData is 0.
- R2: A burst starts only when fifoCount is strictly greater than 255 at a rising edge in the wait state. A count of 255 never starts one. txFrame goes high in the cycle after that edge.
- R3: Once started, txFrame stays high for exactly 272 consecutive cycles.
- R4: Inside a frame, txLine is high for 16 cycles and then low for 1 cycle, and this repeats 16 times. txLine is never high while txFrame is low.
- R5: fifoRd is high in exactly the cycles where txLine is high, so each burst reads 256 words.
- R6: On each falling edge where txFrame and txLine are both high, txData takes the FIFO head word. Words therefore appear in FIFO order, one per line cycle.
- R7: While txFrame or txLine is low, txData holds its last value.
- R8: After a burst, txFrame is low for at least one cycle. A new burst then starts at once if fifoCount is still above 255.
- R9: A reset that arrives in the middle of a burst ends the burst at once. With a full FIFO, the burst restarts in the cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| fifoCount | input | 12 | Number of words held in the FIFO |
| fifoData | input | 16 | Head word of the show-ahead FIFO |
| txFrame | output | 1 | Frame strobe, high for the whole burst |
| txLine | output | 1 | Line strobe, high for each sample group |
| txData | output | 16 | Data word, launched on the falling edge |
| fifoRd | output | 1 | FIFO read strobe, one word per high cycle |

## Verification
The strobes move one rising edge after the condition that causes them. A count presented before edge N therefore shows up as txFrame high in the cycle after edge N. The bench samples the strobes 5 ns after each rising edge, and it samples txData 5 ns after each falling edge, since that is the only edge that moves the data. The expected line pattern and word sequence are derived from the burst cycle index, counted from the first sampled high on txFrame. The bench FIFO model updates its count and head word only after both samples of a cycle have been taken. This keeps every pop aligned with the rising edge that follows the read strobe.

// File: rtl/flt_pkg.sv
package flt_pkg;

  typedef enum logic {
    ST_WAIT   = 1'b0,
    ST_ACTIVE = 1'b1
  } txState_t;

  typedef struct packed {
    logic frameOn;
    logic lineOn;
    logic popWord;
  } txStrobe_t;

endpackage

// File: rtl/flt_ctrl.sv
module flt_ctrl
  import flt_pkg::*;
#(
  parameter int COUNT_W = 12,
  parameter int THRESH  = 255,
  parameter int LINES   = 16,
  parameter int SAMPLES = 16,
  parameter int GAP     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COUNT_W-1:0] fifoCount,
  output txStrobe_t          strobe
);

  localparam int PERIOD = SAMPLES + GAP;
  localparam int IDX_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;

  txState_t          stateQ;
  logic              frameQ;
  logic              lineQ;
  logic [IDX_W-1:0]  slotIdx;
  logic [LINE_W-1:0] lineIdx;

  logic ready;
  logic txHit;
  logic lastSlot;
  logic lastLine;
  logic lastSample;

  assign ready      = fifoCount > COUNT_W'(THRESH);
  assign txHit      = (stateQ == ST_WAIT) && ready;
  assign lastSlot   = slotIdx == IDX_W'(PERIOD - 1);
  assign lastLine   = lineIdx == LINE_W'(LINES - 1);
  assign lastSample = slotIdx == IDX_W'(SAMPLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_WAIT;
      frameQ  <= 1'b0;
      lineQ   <= 1'b0;
      slotIdx <= '0;
      lineIdx <= '0;
    end else begin
      unique case (stateQ)
        ST_WAIT: begin
          if (txHit) begin
            stateQ  <= ST_ACTIVE;
            frameQ  <= 1'b1;
            lineQ   <= 1'b1;
            slotIdx <= '0;
            lineIdx <= '0;
          end
        end
        ST_ACTIVE: begin
          if (lastSlot) begin
            slotIdx <= '0;
            if (lastLine) begin
              stateQ <= ST_WAIT;
              frameQ <= 1'b0;
              lineQ  <= 1'b0;
            end else begin
              lineIdx <= lineIdx + 1'b1;
              lineQ   <= 1'b1;
            end
          end else begin
            slotIdx <= slotIdx + 1'b1;
            lineQ   <= lineQ && !lastSample;
          end
        end
        default: stateQ <= ST_WAIT;
      endcase
    end
  end

  assign strobe.frameOn = frameQ;
  assign strobe.lineOn  = lineQ;
  assign strobe.popWord = lineQ;

endmodule

// File: rtl/flt_datapath.sv
module flt_datapath
  import flt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] fifoData,
  output logic [DATA_W-1:0] txData
);

  logic capture;

  assign capture = strobe.frameOn && strobe.lineOn && strobe.popWord;

  always_ff @(negedge clk) begin
    if (rst) begin
      txData <= '0;
    end else if (capture) begin
      txData <= fifoData;
    end
  end

endmodule

// File: rtl/frame_line_tx.sv
module frame_line_tx
  import flt_pkg::*;
#(
  parameter int COUNT_W = 12,
  parameter int DATA_W  = 16,
  parameter int THRESH  = 255,
  parameter int LINES   = 16,
  parameter int SAMPLES = 16,
  parameter int GAP     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COUNT_W-1:0] fifoCount,
  input  logic [DATA_W-1:0]  fifoData,
  output logic               txFrame,
  output logic               txLine,
  output logic [DATA_W-1:0]  txData,
  output logic               fifoRd
);

  txStrobe_t strobe;

  flt_ctrl #(
    .COUNT_W(COUNT_W),
    .THRESH (THRESH),
    .LINES  (LINES),
    .SAMPLES(SAMPLES),
    .GAP    (GAP)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .fifoCount(fifoCount),
    .strobe   (strobe)
  );

  flt_datapath #(
    .DATA_W(DATA_W)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .fifoData(fifoData),
    .txData  (txData)
  );

  assign txFrame = strobe.frameOn;
  assign txLine  = strobe.lineOn;
  assign fifoRd  = strobe.popWord;

endmodule

// File: rtl/frame_line_tx_chk.sv
module frame_line_tx_chk #(
  parameter int COUNT_W = 12,
  parameter int DATA_W  = 16,
  parameter int THRESH  = 255
) (
  input logic               clk,
  input logic               rst,
  input logic [COUNT_W-1:0] fifoCount,
  input logic               txFrame,
  input logic               txLine,
  input logic [DATA_W-1:0]  txData,
  input logic               fifoRd
);

  p_line_inside_frame_r4: assert property (@(posedge clk) disable iff (rst)
    txLine |-> txFrame);

  p_start_needs_fill_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(txFrame) |-> ($past(fifoCount) > COUNT_W'(THRESH)));

  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!txFrame && !$past(rst)) |-> $stable(txData));

  p_frame_ends_on_gap_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(txFrame) && !$past(rst)) |-> !$past(txLine));

  p_read_only_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
    fifoRd |-> txFrame);

endmodule

bind frame_line_tx frame_line_tx_chk #(
  .COUNT_W(COUNT_W),
  .DATA_W (DATA_W),
  .THRESH (THRESH)
) uChk (
  .clk      (clk),
  .rst      (rst),
  .fifoCount(fifoCount),
  .txFrame  (txFrame),
  .txLine   (txLine),
  .txData   (txData),
  .fifoRd   (fifoRd)
);

// File: tb/tb_frame_line_tx.sv
`timescale 1ns/1ps
module tb_frame_line_tx;

  localparam int FRAME_LEN = 272;
  localparam int SLOT_LEN  = 17;

  typedef struct packed {
    logic [11:0] startCnt;
    logic [15:0] base;
    logic        expStart;
  } scen_t;

  localparam scen_t SCEN [4] = '{
    '{startCnt: 12'd255, base: 16'h1000, expStart: 1'b0},
    '{startCnt: 12'd256, base: 16'h2000, expStart: 1'b1},
    '{startCnt: 12'd300, base: 16'hA5A0, expStart: 1'b1},
    '{startCnt: 12'd700, base: 16'hFFF0, expStart: 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] fifoCount = '0;
  logic [15:0] fifoData = '0;
  logic        txFrame, txLine, fifoRd;
  logic [15:0] txData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic sFrame, sLine, sRd;
  logic [15:0] sData;

  always #10 clk = ~clk;

  frame_line_tx dut (
    .clk      (clk),
    .rst      (rst),
    .fifoCount(fifoCount),
    .fifoData (fifoData),
    .txFrame  (txFrame),
    .txLine   (txLine),
    .txData   (txData),
    .fifoRd   (fifoRd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock cycle: strobes sampled after the rising edge, data after the
  // falling edge, then the show-ahead FIFO model pops if a read was seen.
  task automatic cycle();
    @(posedge clk);
    #5;
    sFrame = txFrame;
    sLine  = txLine;
    sRd    = fifoRd;
    #10;
    sData = txData;
    if (sRd) begin
      fifoData  = fifoData + 16'd1;
      fifoCount = fifoCount - 12'd1;
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    fifoCount = '0;
    cycle();
    cycle();
    rst = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cycle();
    cycle();
    check("R1 frame", 32'(sFrame), 0);
    check("R1 line", 32'(sLine), 0);
    check("R1 rd", 32'(sRd), 0);
    check("R1 data", 32'(sData), 0);
    rst = 1'b0;

    foreach (SCEN[i]) begin
      doReset();
      fifoCount = SCEN[i].startCnt;
      fifoData  = SCEN[i].base;
      if (!SCEN[i].expStart) begin
        for (int c = 0; c < 30; c++) begin
          cycle();
          check("R2 no start at 255", 32'(sFrame), 0);
          check("R2 no read", 32'(sRd), 0);
          check("R7 data idle", 32'(sData), 0);
        end
      end else begin
        logic [15:0] lastWord;
        int pops;
        bit retrig;
        lastWord = 16'h0000;
        pops = 0;
        retrig = (int'(SCEN[i].startCnt) - 256) > 255;
        cycle();
        check("R2 frame starts", 32'(sFrame), 1);
        for (int k = 0; k < FRAME_LEN + 2; k++) begin
          logic eFrame, eLine;
          if (k > 0) cycle();
          if (k < FRAME_LEN) begin
            eFrame = 1'b1;
            eLine  = (k % SLOT_LEN) < 16;
          end else if (k == FRAME_LEN) begin
            eFrame = 1'b0;
            eLine  = 1'b0;
          end else begin
            eFrame = retrig;
            eLine  = retrig;
          end
          check((k < FRAME_LEN) ? "R3 frame" : "R8 frame end", 32'(sFrame), 32'(eFrame));
          check("R4 line", 32'(sLine), 32'(eLine));
          check("R5 read", 32'(sRd), 32'(eLine));
          if (eLine) begin
            lastWord = SCEN[i].base + 16'(pops);
            pops++;
          end
          check(eLine ? "R6 data" : "R7 data hold", 32'(sData), 32'(lastWord));
          if (k == FRAME_LEN - 1)
            check("R5 words per frame", 32'(pops), 256);
        end
      end
    end

    // R9: reset in the middle of a burst, then restart with a full FIFO
    doReset();
    fifoCount = 12'd400;
    fifoData  = 16'h0100;
    for (int c = 0; c < 40; c++) cycle();
    check("R9 frame active", 32'(sFrame), 1);
    rst = 1'b1;
    cycle();
    check("R9 frame aborted", 32'(sFrame), 0);
    check("R9 line aborted", 32'(sLine), 0);
    check("R9 read stopped", 32'(sRd), 0);
    check("R9 data cleared", 32'(sData), 0);
    rst = 1'b0;
    begin
      logic [15:0] head;
      head = fifoData;
      cycle();
      check("R9 restart frame", 32'(sFrame), 1);
      check("R9 restart line", 32'(sLine), 1);
      check("R6 first word", 32'(sData), 32'(head));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule